// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block sits between a set of peripheral interrupt request lines and a processor core. It picks one request to present to the core. Each request line has its own enable, and one global enable gates every line. Each line also carries a two-bit priority level made of a high bit and a low bit held in two paired priority vectors. The block presents the chosen source index and its level to the core, together with a request strobe. It then waits for the core to acknowledge.

The controller records which priority levels have a routine running in a four-bit in-service mask, with one bit per level. The mask acts as a stack of nested levels. An acknowledge pushes the level of the acknowledged source. A return-from-interrupt strobe pops the highest level present. A new request reaches the core only if its level is strictly above the highest level in service, so a routine at the top level cannot be interrupted. Among pending requests, the highest level wins. Within one level, the lowest source index wins.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cpu_req` is 0 and `insvc_mask` is 0000.
- R2: A source whose `src_en` bit is 0 is never presented to the core, even while its pending line is high.
- R3: While `glob_en` is 0, `cpu_req` is 0 in the following cycle, whatever the pending lines are.
- R4: A source's level is {`prio_hi[i]`, `prio_lo[i]`}, where 3 is highest and 0 is lowest. When enabled requests of different levels are pending, the one of highest level is presented, and `cpu_lvl` shows that level.
- R5: Among enabled pending requests of the same level, the one with the lowest source index is presented on `cpu_src`.
- R6: The winner is registered. A qualifying request sampled at one rising edge drives `cpu_req`, `cpu_src` and `cpu_lvl` from that edge on, so there is one cycle of latency.
- R7: `cpu_req` stays high while its request still qualifies and is not acknowledged. After an edge with `cpu_req` and `irq_ack` both high, `cpu_req` is 0 and bit `cpu_lvl` of `insvc_mask` is set.
- R8: While any level is in service, a request is presented only if its level is strictly greater than the highest set bit of `insvc_mask`. Requests at the same or a lower level wait.
- R9: While bit 3 of `insvc_mask` is set, `cpu_req` stays 0.
- R10: A return strobe `irq_ret` clears only the highest set bit of `insvc_mask`. A return while the mask is 0000 leaves it unchanged.
- R11: When the acknowledge and the return fall in the same cycle, the return clears the highest bit of the old mask and the acknowledged level is set in the same edge.
- R12: An `irq_ack` while `cpu_req` is 0 has no effect on `insvc_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pend | input | NUM_SRC (12) | Pending request line per source |
| src_en | input | NUM_SRC (12) | Per-source enable |
| glob_en | input | 1 | Global enable for all sources |
| prio_hi | input | NUM_SRC (12) | High bit of each source's level |
| prio_lo | input | NUM_SRC (12) | Low bit of each source's level |
| irq_ack | input | 1 | Core acknowledges the presented request |
| irq_ret | input | 1 | Core returns from the current routine |
| cpu_req | output | 1 | Request to the core |
| cpu_src | output | $clog2(NUM_SRC) (4) | Index of the presented source |
| cpu_lvl | output | 2 | Level of the presented source |
| insvc_mask | output | 4 | Levels currently in service, one bit per level |

## Verification
The acknowledge of a nested request and the return from the routine below it can arrive in the same clock. In that cycle a push and a pop hit the in-service mask together. The bench provokes this case by first putting level 1 in service. It then raises a level-2 request, waits for it to be presented, and drives `irq_ack` and `irq_ret` in one cycle. The expected mask after that edge is exactly 0100: the popped level-1 bit is gone and the pushed level-2 bit is present, with `cpu_req` low.

// File: rtl/prio_irq_pkg.sv
// Package: shared level type and derived constants for the interrupt controller.
// Assumes a fixed two-bit level encoding, which gives four levels.
package prio_irq_pkg;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/prio_irq_sel.sv
// Module: prio_irq_sel
// Purpose: combinational selection of the winning request. Inside each level
// the lowest qualified index wins. Across levels the highest level wins.
// Assumes: pending lines are already synchronous to clk.
module prio_irq_sel
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] hi,
    input  logic [NUM_SRC-1:0] lo,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output lvl_t               lvl
);
    logic [NUM_LVL-1:0]       lvl_any;
    logic [NUM_LVL*IDX_W-1:0] lvl_idx_flat;

    for (genvar L = 0; L < NUM_LVL; L++) begin : g_lvl
        logic [NUM_SRC-1:0] hit;
        logic [IDX_W-1:0]   first;

        // Mark enabled pending sources whose level equals L.
        always_comb begin
            for (int i = 0; i < NUM_SRC; i++) begin
                hit[i] = pend[i] & en[i] & (lvl_t'({hi[i], lo[i]}) == lvl_t'(L));
            end
        end

        // Find the lowest marked index in this level (fixed rank).
        always_comb begin
            first = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
                if (hit[i]) first = IDX_W'(i);
            end
        end

        assign lvl_any[L] = |hit;
        assign lvl_idx_flat[L*IDX_W +: IDX_W] = first;
    end

    // Pick the highest level that has a candidate.
    always_comb begin
        any = 1'b0;
        idx = '0;
        lvl = '0;
        for (int L = 0; L < NUM_LVL; L++) begin
            if (lvl_any[L]) begin
                any = 1'b1;
                idx = lvl_idx_flat[L*IDX_W +: IDX_W];
                lvl = lvl_t'(L);
            end
        end
    end
endmodule

// File: rtl/prio_irq_stack.sv
// Module: prio_irq_stack
// Purpose: in-service level mask. An accepted acknowledge pushes its level.
// A return pops the highest set level. Both may act on the same edge.
// Assumes: a pushed level is always above the current highest level.
module prio_irq_stack
    import prio_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  lvl_t               push_lvl,
    input  logic               pop,
    output logic [NUM_LVL-1:0] mask,
    output logic               busy,
    output lvl_t               top_lvl
);
    logic [NUM_LVL-1:0] clr_vec;
    logic [NUM_LVL-1:0] set_vec;

    // Derive the highest level currently in service.
    always_comb begin
        busy    = |mask;
        top_lvl = '0;
        for (int L = 0; L < NUM_LVL; L++) begin
            if (mask[L]) top_lvl = lvl_t'(L);
        end
    end

    // Build the one-hot pop and push vectors.
    always_comb begin
        clr_vec = (pop && busy) ? (NUM_LVL'(1) << top_lvl) : '0;
        set_vec = push ? (NUM_LVL'(1) << push_lvl) : '0;
    end

    // Update the mask: pop on the old value, then push.
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= (mask & ~clr_vec) | set_vec;
    end

    assert_ret_pops_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && busy) |=> ($countones(mask) == $countones($past(mask)) - 1));

    assert_ret_idle_noop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !busy) |=> (mask == '0));

    assert_push_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push && busy) |=> (mask[$past(push_lvl)] && !mask[$past(top_lvl)]));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: prio_irq_ctrl (top)
// Purpose: gate requests with the per-source and global enables, select a
// winner, allow it only above the level in service, and register it toward
// the core. Tracks the nested levels in service.
// Assumes: the core pulses irq_ack for one cycle while cpu_req is high, and
// pulses irq_ret once per finished routine.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 12,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               glob_en,
    input  logic [NUM_SRC-1:0] prio_hi,
    input  logic [NUM_SRC-1:0] prio_lo,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               cpu_req,
    output logic [IDX_W-1:0]   cpu_src,
    output logic [LVL_W-1:0]   cpu_lvl,
    output logic [NUM_LVL-1:0] insvc_mask
);
    logic             sel_any;
    logic [IDX_W-1:0] sel_idx;
    lvl_t             sel_lvl;
    logic             busy;
    lvl_t             top_lvl;
    logic             eligible;
    logic             ack_take;
    logic             req_q;
    logic [IDX_W-1:0] src_q;
    lvl_t             lvl_q;

    prio_irq_sel #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_sel (
        .pend (irq_pend),
        .en   (src_en),
        .hi   (prio_hi),
        .lo   (prio_lo),
        .any  (sel_any),
        .idx  (sel_idx),
        .lvl  (sel_lvl)
    );

    prio_irq_stack u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_take),
        .push_lvl (lvl_q),
        .pop      (irq_ret),
        .mask     (insvc_mask),
        .busy     (busy),
        .top_lvl  (top_lvl)
    );

    // Qualify the winner against the global enable and the level in service.
    always_comb begin
        eligible = glob_en && sel_any && (!busy || (sel_lvl > top_lvl));
        ack_take = req_q && irq_ack;
    end

    // Register the winner. An acknowledge withdraws the request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            src_q <= '0;
            lvl_q <= '0;
        end else if (ack_take) begin
            req_q <= 1'b0;
        end else begin
            req_q <= eligible;
            src_q <= sel_idx;
            lvl_q <= sel_lvl;
        end
    end

    assign cpu_req = req_q;
    assign cpu_src = src_q;
    assign cpu_lvl = lvl_q;

    assert_gate_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !cpu_req);

    assert_ack_drops_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && irq_ack) |=> !cpu_req);

    assert_ack_marks_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && irq_ack) |=> insvc_mask[$past(cpu_lvl)]);

    assert_strict_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && busy) |-> (cpu_lvl > top_lvl));

    assert_top_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        insvc_mask[NUM_LVL-1] |-> !cpu_req);

    assert_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req && irq_ack && !irq_ret) |=> $stable(insvc_mask));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_pend = '0;
    logic [N-1:0] src_en = '0;
    logic         glob_en = 1'b1;
    logic [N-1:0] prio_hi = '0;
    logic [N-1:0] prio_lo = '0;
    logic         irq_ack = 1'b0;
    logic         irq_ret = 1'b0;
    logic         cpu_req;
    logic [3:0]   cpu_src;
    logic [1:0]   cpu_lvl;
    logic [3:0]   insvc_mask;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .src_en(src_en),
        .glob_en(glob_en), .prio_hi(prio_hi), .prio_lo(prio_lo),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .cpu_req(cpu_req),
        .cpu_src(cpu_src), .cpu_lvl(cpu_lvl), .insvc_mask(insvc_mask)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic add_src(input int i, input int lvl);
        irq_pend[i] = 1'b1;
        src_en[i]   = 1'b1;
        prio_hi[i]  = lvl[1];
        prio_lo[i]  = lvl[0];
    endtask

    task automatic clear_srcs();
        irq_pend = '0; src_en = '0; prio_hi = '0; prio_lo = '0;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic ret_once();
        irq_ret = 1'b1; step(); irq_ret = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 req after reset", cpu_req, 0);
        check("R1 mask after reset", insvc_mask, 0);
    endtask

    task automatic t_enable();
        irq_pend[5] = 1'b1; prio_hi[5] = 1'b1;
        step(); step();
        check("R2 disabled source req", cpu_req, 0);
        src_en[5] = 1'b1;
        check("R6 no req before edge", cpu_req, 0);
        step();
        check("R6 req one edge later", cpu_req, 1);
        check("R6 src index", cpu_src, 5);
        clear_srcs(); step();
    endtask

    task automatic t_global();
        glob_en = 1'b0;
        add_src(7, 2);
        step(); step();
        check("R3 global disable req", cpu_req, 0);
        glob_en = 1'b1; step();
        check("R3 req after re-enable", cpu_req, 1);
        clear_srcs(); step();
    endtask

    task automatic t_level();
        add_src(2, 1); add_src(9, 3); add_src(0, 0);
        step();
        check("R4 highest level src", cpu_src, 9);
        check("R4 highest level lvl", cpu_lvl, 3);
        clear_srcs(); step();
    endtask

    task automatic t_rank();
        add_src(7, 2); add_src(3, 2); add_src(11, 2);
        step();
        check("R5 same level rank", cpu_src, 3);
        check("R5 same level lvl", cpu_lvl, 2);
        clear_srcs(); step();
    endtask

    task automatic t_hold_ack();
        add_src(8, 2);
        step(); step(); step();
        check("R7 req held", cpu_req, 1);
        ack_once();
        check("R7 req dropped after ack", cpu_req, 0);
        check("R7 mask after ack", insvc_mask, 4'b0100);
        step();
        check("R8 same level stays out", cpu_req, 0);
        clear_srcs(); step();
    endtask

    task automatic t_preempt();
        add_src(4, 1); step();
        check("R8 lower level waits", cpu_req, 0);
        add_src(10, 3); step();
        check("R8 higher level preempts", cpu_req, 1);
        check("R8 higher level src", cpu_src, 10);
        ack_once();
        check("R7 nested mask", insvc_mask, 4'b1100);
        add_src(0, 3); step(); step();
        check("R9 top level locked", cpu_req, 0);
        clear_srcs(); step();
    endtask

    task automatic t_ret();
        ret_once();
        check("R10 pop highest", insvc_mask, 4'b0100);
        ret_once();
        check("R10 pop last", insvc_mask, 4'b0000);
        ret_once();
        check("R10 pop on empty", insvc_mask, 4'b0000);
    endtask

    task automatic t_ack_ret();
        add_src(6, 1); step();
        check("R11 level1 presented", cpu_lvl, 1);
        ack_once();
        check("R11 level1 in service", insvc_mask, 4'b0010);
        add_src(1, 2); step();
        check("R11 level2 presented", cpu_src, 1);
        irq_ack = 1'b1; irq_ret = 1'b1; step();
        irq_ack = 1'b0; irq_ret = 1'b0;
        check("R11 mask after ack with ret", insvc_mask, 4'b0100);
        check("R11 req after ack with ret", cpu_req, 0);
        clear_srcs(); step();
        ret_once();
        check("R11 mask cleaned up", insvc_mask, 0);
    endtask

    task automatic t_stray_ack();
        step();
        check("R12 idle req", cpu_req, 0);
        ack_once();
        check("R12 stray ack mask", insvc_mask, 0);
        step();
        check("R12 req after stray ack", cpu_req, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_enable();
        t_global();
        t_level();
        t_rank();
        t_hold_ack();
        t_preempt();
        t_ret();
        t_ack_ret();
        t_stray_ack();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule